// File: doc/BRIEF.md
# Timer-Triggered ADC Sample-and-Convert Sequencer

This block is the digital control around a successive-approximation converter. A compare output from a timer starts a cycle. The block opens a sample window, runs a fixed conversion phase, and stores the result in a memory slot. It then moves on through a table of per-slot channel selects. The analog front end is not part of the block. Its result arrives on a digital input, which the block captures at the end of each conversion.

The sample window has two modes. In the timed mode, the window is set by a counted number of converter ticks, chosen by a small code. In the gated mode, the trigger pulse sets the window: the rising edge opens it and the falling edge closes it. A sequence begins at a programmed slot and visits consecutive slots. It stops after the first slot that carries an end mark. When no later slot is marked, it stops at the highest slot.

The converter tick is an enable strobe, not a derived clock. It comes from one of three source strobes followed by a divider with ratio 1 to 8. Each slot has a result register, a sticky flag and an interrupt enable.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy, sampling and irq are low, and every flag and result register is zero.
- R2: `cnvTick` pulses once per `divSel`+1 pulses of the source strobe picked by `clkSel` (0, 1 or 2 picks that bit of `srcTick`). `clkSel`=3 gives no ticks.
- R3: With `timedSample`=1, each sample window lasts exactly 4·2^`sampleCode` converter ticks.
- R4: Each conversion lasts exactly 13 converter ticks. On the 13th tick, `convResult` is written to the current slot's result field, which is bits [12·s+11 : 12·s] of `memData`.
- R5: With `timedSample`=0, the window is open from the trigger's rising edge until its falling edge. With one tick per clock, the slot's flag becomes visible 14 clock cycles after the falling edge is driven.
- R6: A sequence converts consecutive slots. It starts at `startSlot` and ends after the first slot at or above it whose `slotEos` bit is 1, or at slot 3 when no such bit is set. A marked start slot alone gives one conversion.
- R7: `trigSel` values 0, 1 and 2 select that bit of `timerCmp`, and a cycle starts on its rising edge. Edges on unselected bits, and any edge with `trigSel`=3, start nothing.
- R8: No trigger starts a cycle while `enable` is low.
- R9: `busy` rises together with `sampling` at the first sample cycle and falls as the final result is stored. A rising edge during a sample window or a conversion has no effect.
- R10: A slot's flag in `intFlag` is set when its result is stored and is cleared by a 1 on its `flagClr` bit. `irq` is high when any flag is set together with its `intEn` bit.
- R11: `chanSel` shows the 4-bit channel of the current slot, taken from `slotChan` bits [4·s+3 : 4·s], and holds it for the whole sample window.
- R12: In gated mode, after a slot that does not end the sequence, the block stays busy and not sampling until the next selected rising edge, which opens the next slot's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new triggers to start a window |
| timedSample | input | 1 | 1: counted window, 0: trigger-gated window |
| trigSel | input | 2 | Trigger source select (3 = none) |
| timerCmp | input | 3 | Timer compare outputs |
| clkSel | input | 2 | Converter clock source select (3 = none) |
| srcTick | input | 3 | Source enable strobes |
| divSel | input | 3 | Divider ratio minus one |
| sampleCode | input | 2 | Window length code, 4·2^code ticks |
| startSlot | input | 2 | First slot of a sequence |
| slotChan | input | 16 | Per-slot 4-bit channel selects |
| slotEos | input | 4 | Per-slot end marks |
| intEn | input | 4 | Per-slot interrupt enables |
| flagClr | input | 4 | Per-slot flag clear, write 1 |
| convResult | input | 12 | Digital converter result |
| cnvTick | output | 1 | Converter tick strobe |
| busy | output | 1 | Sequence in progress |
| sampling | output | 1 | Sample window open |
| chanSel | output | 4 | Channel of the current slot |
| memData | output | 48 | Per-slot results, packed |
| intFlag | output | 4 | Per-slot result flags |
| irq | output | 1 | OR of enabled flags |

## Verification
The assertions assume that `timedSample`, `slotChan`, `startSlot`, `slotEos` and the selectors do not change while `busy` is high, and that `timerCmp` is synchronous to `clk`. The bench changes configuration only at a falling clock edge with `busy` low. It drives trigger pulses only on the selected bit, except in the tests that check unselected bits, and it holds `convResult` to a pure function of `chanSel` and a per-run tag. Under those conditions, every window end and every sequence end coincides with a converter tick, and at most one flag can newly rise in a cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV,
    ST_ARM
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic loadStart;
    logic advance;
    logic sampClr;
    logic sampRun;
    logic convClr;
    logic convRun;
    logic store;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic sampDone;
    logic convDone;
    logic lastSlot;
  } seqStatus_t;

endpackage

// File: rtl/adc_timebase.sv
module adc_timebase #(
  parameter int SRC_N  = 3,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 3,
  parameter int TRIG_N = 3,
  parameter int TSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcTick,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic [DIV_W-1:0]  divSel,
  input  logic [TRIG_N-1:0] timerCmp,
  input  logic [TSEL_W-1:0] trigSel,
  output logic              cnvTick,
  output logic              trigRise,
  output logic              trigFall
);

  logic             srcOn;
  logic             trigNow;
  logic             trigPrev;
  logic [DIV_W-1:0] divCnt;

  // source mux; out-of-range select yields no strobe
  always_comb begin
    srcOn = 1'b0;
    for (int i = 0; i < SRC_N; i++)
      if (clkSel == SEL_W'(i)) srcOn = srcTick[i];
  end

  always_comb begin
    trigNow = 1'b0;
    for (int i = 0; i < TRIG_N; i++)
      if (trigSel == TSEL_W'(i)) trigNow = timerCmp[i];
  end

  // >= keeps the divider sane if the ratio shrinks below the current count
  assign cnvTick = srcOn && (divCnt >= divSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      trigPrev <= 1'b0;
    end else begin
      if (srcOn) divCnt <= cnvTick ? '0 : divCnt + 1'b1;
      trigPrev <= trigNow;
    end
  end

  assign trigRise = trigNow & ~trigPrev;
  assign trigFall = ~trigNow & trigPrev;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       timedSample,
  input  logic       trigRise,
  input  logic       trigFall,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       sampling
);

  seqState_t state;
  seqState_t nxt;

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_IDLE: begin
        if (enable && trigRise) begin
          strb.loadStart = 1'b1;
          strb.sampClr   = 1'b1;
          nxt            = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        strb.sampRun = timedSample;
        if (timedSample ? stat.sampDone : trigFall) begin
          strb.convClr = 1'b1;
          nxt          = ST_CONV;
        end
      end
      ST_CONV: begin
        strb.convRun = 1'b1;
        if (stat.convDone) begin
          strb.store = 1'b1;
          if (stat.lastSlot) begin
            nxt = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            if (timedSample) begin
              strb.sampClr = 1'b1;
              nxt          = ST_SAMPLE;
            end else begin
              nxt = ST_ARM;
            end
          end
        end
      end
      ST_ARM: begin
        if (enable && trigRise) begin
          strb.sampClr = 1'b1;
          nxt          = ST_SAMPLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign busy     = (state != ST_IDLE);
  assign sampling = (state == ST_SAMPLE);

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int CH_W       = 4,
  parameter int RES_W      = 12,
  parameter int SHT_W      = 2,
  parameter int CONV_TICKS = 13,
  parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strb,
  input  logic                      cnvTick,
  input  logic [SLOT_W-1:0]         startSlot,
  input  logic [SHT_W-1:0]          sampleCode,
  input  logic [NUM_SLOTS*CH_W-1:0] slotChan,
  input  logic [NUM_SLOTS-1:0]      slotEos,
  input  logic [NUM_SLOTS-1:0]      flagClr,
  input  logic [NUM_SLOTS-1:0]      intEn,
  input  logic [RES_W-1:0]          convResult,
  output seqStatus_t                stat,
  output logic [CH_W-1:0]           chanSel,
  output logic [NUM_SLOTS*RES_W-1:0] memData,
  output logic [NUM_SLOTS-1:0]      intFlag,
  output logic                      irq
);

  localparam int SAMP_BASE = 4;
  localparam int SAMP_MAX  = SAMP_BASE << ((1 << SHT_W) - 1);
  localparam int SAMP_W    = $clog2(SAMP_MAX);
  localparam int CONV_W    = $clog2(CONV_TICKS);

  logic [SLOT_W-1:0] slot;
  logic [SAMP_W-1:0] sampCnt;
  logic [SAMP_W-1:0] sampLast;
  logic [CONV_W-1:0] convCnt;

  always_comb sampLast = SAMP_W'((SAMP_BASE << sampleCode) - 1);

  assign stat.sampDone = cnvTick && (sampCnt == sampLast);
  assign stat.convDone = cnvTick && (convCnt == CONV_W'(CONV_TICKS - 1));
  assign stat.lastSlot = slotEos[slot] || (slot == SLOT_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot    <= '0;
      sampCnt <= '0;
      convCnt <= '0;
    end else begin
      if (strb.loadStart)    slot <= startSlot;
      else if (strb.advance) slot <= slot + 1'b1;

      if (strb.sampClr)                sampCnt <= '0;
      else if (strb.sampRun && cnvTick) sampCnt <= sampCnt + 1'b1;

      if (strb.convClr)                convCnt <= '0;
      else if (strb.convRun && cnvTick) convCnt <= convCnt + 1'b1;
    end
  end

  assign chanSel = slotChan[slot*CH_W +: CH_W];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic [RES_W-1:0] memReg;
    logic             hit;

    assign hit = strb.store && (slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        memReg     <= '0;
        intFlag[g] <= 1'b0;
      end else begin
        if (hit) memReg <= convResult;
        if (hit)             intFlag[g] <= 1'b1;
        else if (flagClr[g]) intFlag[g] <= 1'b0;
      end
    end

    assign memData[g*RES_W +: RES_W] = memReg;
  end

  assign irq = |(intFlag & intEn);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int CH_W       = 4,
  parameter int RES_W      = 12,
  parameter int SHT_W      = 2,
  parameter int DIV_W      = 3,
  parameter int CONV_TICKS = 13,
  parameter int SRC_N      = 3,
  parameter int TRIG_N     = 3,
  parameter int SLOT_W     = $clog2(NUM_SLOTS),
  parameter int SEL_W      = $clog2(SRC_N + 1),
  parameter int TSEL_W     = $clog2(TRIG_N + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       timedSample,
  input  logic [TSEL_W-1:0]          trigSel,
  input  logic [TRIG_N-1:0]          timerCmp,
  input  logic [SEL_W-1:0]           clkSel,
  input  logic [SRC_N-1:0]           srcTick,
  input  logic [DIV_W-1:0]           divSel,
  input  logic [SHT_W-1:0]           sampleCode,
  input  logic [SLOT_W-1:0]          startSlot,
  input  logic [NUM_SLOTS*CH_W-1:0]  slotChan,
  input  logic [NUM_SLOTS-1:0]       slotEos,
  input  logic [NUM_SLOTS-1:0]       intEn,
  input  logic [NUM_SLOTS-1:0]       flagClr,
  input  logic [RES_W-1:0]           convResult,
  output logic                       cnvTick,
  output logic                       busy,
  output logic                       sampling,
  output logic [CH_W-1:0]            chanSel,
  output logic [NUM_SLOTS*RES_W-1:0] memData,
  output logic [NUM_SLOTS-1:0]       intFlag,
  output logic                       irq
);

  logic       trigRise;
  logic       trigFall;
  seqStrobe_t strb;
  seqStatus_t stat;

  adc_timebase #(
    .SRC_N(SRC_N), .SEL_W(SEL_W), .DIV_W(DIV_W),
    .TRIG_N(TRIG_N), .TSEL_W(TSEL_W)
  ) u_tb (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .clkSel(clkSel),
    .divSel(divSel), .timerCmp(timerCmp), .trigSel(trigSel),
    .cnvTick(cnvTick), .trigRise(trigRise), .trigFall(trigFall)
  );

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .timedSample(timedSample),
    .trigRise(trigRise), .trigFall(trigFall), .stat(stat),
    .strb(strb), .busy(busy), .sampling(sampling)
  );

  adc_seq_dp #(
    .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .RES_W(RES_W),
    .SHT_W(SHT_W), .CONV_TICKS(CONV_TICKS), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnvTick(cnvTick),
    .startSlot(startSlot), .sampleCode(sampleCode), .slotChan(slotChan),
    .slotEos(slotEos), .flagClr(flagClr), .intEn(intEn),
    .convResult(convResult), .stat(stat), .chanSel(chanSel),
    .memData(memData), .intFlag(intFlag), .irq(irq)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W      = 4,
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 enable,
  input logic                 timedSample,
  input logic                 busy,
  input logic                 sampling,
  input logic                 cnvTick,
  input logic [CH_W-1:0]      chanSel,
  input logic [NUM_SLOTS-1:0] intFlag
);

  // R9: an open window always implies an active sequence
  a_r9_sample_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    sampling |-> busy);

  // R8: a new sequence only begins from a cycle with enable high
  a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable));

  // R3: a counted window closes only on a converter tick
  a_r3_window_ends_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sampling) && timedSample) |-> $past(cnvTick));

  // R4: the final store (end of busy) happens on a converter tick
  a_r4_seq_ends_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(cnvTick));

  // R11: channel select holds for the whole window
  a_r11_chan_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sampling && $past(sampling)) |-> $stable(chanSel));

  // R10: at most one slot flag becomes set per cycle
  a_r10_one_store: assert property (@(posedge clk) disable iff (!rstN)
    $countones(intFlag & ~$past(intFlag)) <= 1);

endmodule

bind adc_seq_top adc_seq_chk #(.CH_W(CH_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .timedSample(timedSample),
  .busy(busy), .sampling(sampling), .cnvTick(cnvTick),
  .chanSel(chanSel), .intFlag(intFlag)
);

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        timedSample = 1'b1;
  logic [1:0]  trigSel = 2'd0;
  logic [2:0]  timerCmp = 3'b000;
  logic [1:0]  clkSel = 2'd0;
  logic [2:0]  srcTick = 3'b111;
  logic [2:0]  divSel = 3'd0;
  logic [1:0]  sampleCode = 2'd0;
  logic [1:0]  startSlot = 2'd0;
  logic [15:0] slotChan = {4'd9, 4'd2, 4'd14, 4'd5};
  logic [3:0]  slotEos = 4'b0000;
  logic [3:0]  intEn = 4'b0000;
  logic [3:0]  flagClr = 4'b0000;
  logic [11:0] convResult;
  logic        cnvTick, busy, sampling, irq;
  logic [3:0]  chanSel, intFlag;
  logic [47:0] memData;
  logic [7:0]  runTag = 8'd0;

  int checks = 0;
  int errors = 0;
  int sampTk = 0;
  int convTk = 0;
  int cycles = 0;
  bit busySeen = 1'b0;

  adc_seq_top u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .timedSample(timedSample),
    .trigSel(trigSel), .timerCmp(timerCmp), .clkSel(clkSel),
    .srcTick(srcTick), .divSel(divSel), .sampleCode(sampleCode),
    .startSlot(startSlot), .slotChan(slotChan), .slotEos(slotEos),
    .intEn(intEn), .flagClr(flagClr), .convResult(convResult),
    .cnvTick(cnvTick), .busy(busy), .sampling(sampling),
    .chanSel(chanSel), .memData(memData), .intFlag(intFlag), .irq(irq)
  );

  always #2 clk = ~clk;

  // converter model: result depends only on channel and run
  always_comb convResult = 12'h300 + 12'(chanSel) * 12'd17 + 12'(runTag);

  always @(negedge clk) begin
    if (busy) busySeen = 1'b1;
    if (busy && cnvTick) begin
      if (sampling) sampTk++;
      else          convTk++;
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expRes(input int slotIdx);
    return 12'h300 + 12'(slotChan[slotIdx*4 +: 4]) * 12'd17 + 12'(runTag);
  endfunction

  task automatic run_timer(input int s, input int e, input int code, input int dv,
                           input int csel, input int tsel, input bit extra);
    int w, last, n;
    logic [3:0] mask;
    @(negedge clk);
    timedSample = 1'b1; startSlot = 2'(s); slotEos = 4'(e); sampleCode = 2'(code);
    divSel = 3'(dv); clkSel = 2'(csel); trigSel = 2'(tsel); flagClr = 4'hF;
    runTag = runTag + 8'd1;
    @(negedge clk);
    flagClr = 4'h0; sampTk = 0; convTk = 0;
    timerCmp[tsel] = 1'b1;
    w = 0;
    while (!busy && w < 10) begin @(negedge clk); w++; end
    chk(busy, "R7 selected trigger starts", busy, 1);
    repeat (2) @(negedge clk);
    timerCmp[tsel] = 1'b0;
    if (extra) begin
      repeat (4) @(negedge clk);
      timerCmp[tsel] = 1'b1;
      repeat (3) @(negedge clk);
      timerCmp[tsel] = 1'b0;
    end
    while (busy) @(negedge clk);
    last = s;
    while (!e[last] && last < 3) last++;
    n = last - s + 1;
    mask = '0;
    for (int i = s; i <= last; i++) mask[i] = 1'b1;
    chk(intFlag == mask, "R6 visited slots", intFlag, mask);
    chk(sampTk == n * (4 << code), "R3 window ticks", sampTk, n * (4 << code));
    chk(convTk == n * 13, "R4 conversion ticks", convTk, n * 13);
    for (int i = s; i <= last; i++)
      chk(memData[i*12 +: 12] == expRes(i), "R4 R11 stored result",
          memData[i*12 +: 12], expRes(i));
    if (extra)
      chk(sampTk == 4 << code && intFlag == mask, "R9 retrigger ignored", sampTk, 4 << code);
  endtask

  initial begin
    int k, lowSeen, cnt;

    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !sampling && !irq, "R1 control outputs", {busy, sampling, irq}, 0);
    chk(intFlag == 4'h0, "R1 flags", intFlag, 0);
    chk(memData == 48'h0, "R1 results", memData, 0);

    // R8 enable low blocks start
    busySeen = 1'b0;
    timerCmp[0] = 1'b1;
    repeat (10) @(negedge clk);
    timerCmp[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busySeen && intFlag == 4'h0, "R8 no start when disabled", busySeen, 0);
    enable = 1'b1;

    // R7 unselected trigger bits and select 3
    trigSel = 2'd2;
    busySeen = 1'b0;
    timerCmp[0] = 1'b1;
    repeat (3) @(negedge clk);
    timerCmp[0] = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busySeen, "R7 unselected bit ignored", busySeen, 0);
    trigSel = 2'd3;
    timerCmp = 3'b111;
    repeat (3) @(negedge clk);
    timerCmp = 3'b000;
    repeat (10) @(negedge clk);
    chk(!busySeen, "R7 select 3 gives no trigger", busySeen, 0);

    // R3 R4 R6 R11 sweep over start slot and end marks
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 16; e++)
        run_timer(s, e, (s + e) % 4, e % 3, s % 3, (s + e) % 3, 1'b0);

    // R9 retrigger during a window
    run_timer(0, 1, 3, 0, 0, 0, 1'b1);

    // R10 flags, enables, clear
    run_timer(0, 2, 0, 0, 0, 0, 1'b0);
    @(negedge clk);
    intEn = 4'b0100;
    @(negedge clk);
    chk(!irq, "R10 irq masked", irq, 0);
    intEn = 4'b0010;
    @(negedge clk);
    chk(irq, "R10 irq from enabled flag", irq, 1);
    flagClr = 4'b0010;
    @(negedge clk);
    flagClr = 4'b0000;
    chk(intFlag == 4'b0001 && !irq, "R10 flag clear", intFlag, 1);
    intEn = 4'b0000;

    // R5 R12 gated windows
    @(negedge clk);
    timedSample = 1'b0; startSlot = 2'd1; slotEos = 4'b0100; divSel = 3'd0;
    clkSel = 2'd0; srcTick = 3'b111; trigSel = 2'd0; flagClr = 4'hF;
    runTag = runTag + 8'd1;
    @(negedge clk);
    flagClr = 4'h0;
    chk(!busy, "R9 idle before trigger", busy, 0);
    timerCmp[0] = 1'b1;
    @(negedge clk);
    chk(busy && sampling, "R9 busy with first sample cycle", {busy, sampling}, 3);
    lowSeen = 0;
    repeat (20) begin
      if (!sampling) lowSeen++;
      @(negedge clk);
    end
    chk(sampling && lowSeen == 0, "R5 window held while trigger high", lowSeen, 0);
    timerCmp[0] = 1'b0;
    k = 0;
    while (!intFlag[1] && k < 100) begin @(negedge clk); k++; end
    chk(k == 14, "R5 conversion after falling edge", k, 14);
    repeat (10) @(negedge clk);
    chk(busy && !sampling && intFlag == 4'b0010, "R12 waits for next trigger",
        {busy, sampling, intFlag}, 6'b100010);
    timerCmp[0] = 1'b1;
    @(negedge clk);
    chk(sampling, "R12 next window opens", sampling, 1);
    repeat (5) @(negedge clk);
    timerCmp[0] = 1'b0;
    k = 0;
    while (!intFlag[2] && k < 100) begin @(negedge clk); k++; end
    chk(k == 14, "R5 second conversion", k, 14);
    chk(!busy, "R9 busy ends at final store", busy, 0);
    chk(memData[12 +: 12] == expRes(1), "R11 gated slot 1 result", memData[12 +: 12], expRes(1));
    chk(memData[24 +: 12] == expRes(2), "R11 gated slot 2 result", memData[24 +: 12], expRes(2));

    // R2 divider ratios and source selection
    clkSel = 2'd1;
    srcTick = 3'b010;
    for (int d = 0; d < 8; d++) begin
      divSel = 3'(d);
      repeat (10) @(negedge clk);
      while (!cnvTick) @(negedge clk);
      cnt = 0;
      repeat (5 * (d + 1)) begin
        @(negedge clk);
        if (cnvTick) cnt++;
      end
      chk(cnt == 5, "R2 divider ratio", cnt, 5);
    end
    srcTick = 3'b101;
    cnt = 0;
    repeat (40) begin @(negedge clk); if (cnvTick) cnt++; end
    chk(cnt == 0, "R2 unselected source", cnt, 0);
    clkSel = 2'd3;
    srcTick = 3'b111;
    cnt = 0;
    repeat (40) begin @(negedge clk); if (cnvTick) cnt++; end
    chk(cnt == 0, "R2 select 3 gives no ticks", cnt, 0);

    finish_up();
  end

endmodule